// File: doc/BRIEF.md
# Parallel port receive handshake controller

This block sits on the peripheral side of a bidirectional parallel port while the host writes bytes to it. It synchronizes the host's data strobe and detects its edges. On each accepted strobe it writes the data byte once into the write port of a downstream FIFO. It then answers with an acknowledge pulse, a busy level, both, or neither, as a two-bit handshake select chooses.

One shared countdown timer sets every delay. The setup value sets how long the block waits after the strobe ends. The width value sets how long the acknowledge pulse lasts. A fixed three-cycle tail holds busy after the acknowledge when both handshakes are on. Busy is also forced whenever transfers cannot go on: DMA is disabled, or the FIFO is full. A soft reset aborts any transfer in progress and does not disturb the configuration inputs.

Top module: `pp_rx_handshake`

## Requirements

Edge numbering: a strobe edge is counted from the first rising clock edge that samples the new strobe level, which is edge 1. An output "after edge k" is its value in the cycle that follows edge k.

- R1: The handshake select is {cfg_busy_hs, cfg_ack_hs}. 00 means no handshake, 01 means acknowledge only, 10 means busy only and 11 means acknowledge and busy. With cfg_busy_hs low, busy_out never rises because of a transfer.
- R2: If dma_en is low or fifo_full is high in a cycle, busy_out is high in the next cycle, whatever the select.
- R3: For each accepted strobe, wr_en is high for exactly one cycle, after edge 3 of the strobe's rising level. In that cycle wr_data holds data_in as sampled while the strobe was high.
- R4: With cfg_busy_hs high, busy_out is high after edge 3 of the strobe's rising level, which is within three clocks.
- R5: With cfg_ack_hs high, ack_out goes high after edge S+4 of the strobe's falling level and stays high for W cycles. S is cfg_setup and W is the effective width.
- R6: In select 10, busy_out stays high up to and including the cycle after edge S+3 of the falling level. It is low after edge S+4.
- R7: In select 11, busy_out falls 3 clocks after ack_out falls.
- R8: In selects 00 and 10, ack_out stays low.
- R9: The effective width W is cfg_width when that is 3 or more. A cfg_width of 0 to 3 gives W = 3.
- R10: A strobe edge that arrives while a transfer is in progress (idle low) is ignored. It causes no write and does not shift the timing of the transfer in progress.
- R11: One cycle after soft_rst is high, idle is high and ack_out is low. busy_out then reflects only the flow-control inputs, and the next strobe is handled normally.
- R12: After reset, idle is high and ack_out, busy_out and wr_en are low. idle is low from the capture cycle until the last cycle in which the transfer drives ack_out or busy_out, or in select 00 until the strobe's falling level has been seen.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all timer counts are in these cycles |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Aborts any transfer and clears the timer |
| cfg_busy_hs | input | 1 | Select bit: busy is used as a handshake |
| cfg_ack_hs | input | 1 | Select bit: acknowledge pulse is produced |
| cfg_setup | input | TIMER_W | Delay after the strobe ends, in clocks (0 to 127) |
| cfg_width | input | TIMER_W | Acknowledge width in clocks; values below 3 act as 3 |
| dma_en | input | 1 | Transfers allowed; low forces busy |
| fifo_full | input | 1 | FIFO cannot take a byte; forces busy |
| strobe_in | input | 1 | Asynchronous data strobe from the host, active high |
| data_in | input | DATA_W | Parallel data bus |
| wr_en | output | 1 | One-cycle FIFO write enable |
| wr_data | output | DATA_W | Byte captured for the FIFO |
| ack_out | output | 1 | Acknowledge pulse, active high |
| busy_out | output | 1 | Busy level, active high |
| idle | output | 1 | High when no transfer is in progress |

## Verification

The embedded properties check five things on every cycle:

- flow-control busy follows the flow inputs one cycle later;
- a FIFO write never lasts two cycles;
- busy is present at capture in the busy modes;
- an acknowledge that ends on its own has lasted at least three cycles, and in mode 11 busy outlives it;
- a soft reset returns the block to idle.

The exact cycle positions need the bench's scenarios. These are the acknowledge start and length for each setup and width value, the busy hold after the strobe, the 3-cycle tail, the single write per strobe, and a strobe dropped in mid-transfer.

// File: rtl/pp_rx_pkg.sv
package pp_rx_pkg;

    localparam int DEF_DATA_W      = 8;
    localparam int DEF_TIMER_W     = 7;
    localparam int DEF_SYNC_STAGES = 2;
    localparam int DEF_MIN_WIDTH   = 3;
    localparam int DEF_TAIL_CYCLES = 3;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_STRB  = 3'd1,
        ST_SETUP = 3'd2,
        ST_ACK   = 3'd3,
        ST_TAIL  = 3'd4
    } rx_state_e;

    typedef struct packed {
        logic busy_hs;
        logic ack_hs;
    } hs_mode_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } strb_ev_t;

    function automatic logic hs_any(input hs_mode_t m);
        return m.busy_hs | m.ack_hs;
    endfunction

endpackage

// File: rtl/pp_rx_sync.sv
module pp_rx_sync
    import pp_rx_pkg::*;
#(
    parameter int STAGES = DEF_SYNC_STAGES
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     din,
    output strb_ev_t ev
);

    logic [STAGES-1:0] chain;
    logic              last_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[0] <= 1'b0;
                else     chain[0] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= 1'b0;
                else     chain[i] <= chain[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= chain[STAGES-1];
    end

    assign ev.rise = chain[STAGES-1] & ~last_q;
    assign ev.fall = ~chain[STAGES-1] & last_q;

endmodule

// File: rtl/pp_rx_timer.sv
module pp_rx_timer #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr)        cnt_q <= '0;
        else if (load)         cnt_q <= load_val;
        else if (cnt_q != '0)  cnt_q <= cnt_q - W'(1);
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/pp_rx_ctrl.sv
module pp_rx_ctrl
    import pp_rx_pkg::*;
#(
    parameter int TIMER_W     = DEF_TIMER_W,
    parameter int MIN_WIDTH   = DEF_MIN_WIDTH,
    parameter int TAIL_CYCLES = DEF_TAIL_CYCLES
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               soft_rst,
    input  hs_mode_t           mode,
    input  logic [TIMER_W-1:0] setup_cnt,
    input  logic [TIMER_W-1:0] width_cnt,
    input  logic               dma_en,
    input  logic               fifo_full,
    input  strb_ev_t           ev,
    input  logic               tmr_zero,
    output logic               tmr_load,
    output logic [TIMER_W-1:0] tmr_val,
    output logic               capture,
    output logic               ack_out,
    output logic               busy_out,
    output logic               idle
);

    localparam logic [TIMER_W-1:0] MIN_W     = TIMER_W'(MIN_WIDTH);
    localparam logic [TIMER_W-1:0] TAIL_LOAD = TIMER_W'(TAIL_CYCLES - 1);

    rx_state_e          state_q, nxt;
    logic [TIMER_W-1:0] width_eff;
    logic [TIMER_W-1:0] ack_load;
    logic               flow_busy;
    logic               ack_q, busy_q;

    assign width_eff = (width_cnt < MIN_W) ? MIN_W : width_cnt;
    assign ack_load  = width_eff - TIMER_W'(1);
    assign flow_busy = ~dma_en | fifo_full;

    always_comb begin
        nxt      = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        capture  = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (ev.rise) begin
                    capture = 1'b1;
                    nxt     = ST_STRB;
                end
            end
            ST_STRB: begin
                if (ev.fall) begin
                    if (hs_any(mode)) begin
                        nxt      = ST_SETUP;
                        tmr_load = 1'b1;
                        tmr_val  = setup_cnt;
                    end else begin
                        nxt = ST_IDLE;
                    end
                end
            end
            ST_SETUP: begin
                if (tmr_zero) begin
                    if (mode.ack_hs) begin
                        nxt      = ST_ACK;
                        tmr_load = 1'b1;
                        tmr_val  = ack_load;
                    end else begin
                        nxt = ST_IDLE;
                    end
                end
            end
            ST_ACK: begin
                if (tmr_zero) begin
                    if (mode.busy_hs) begin
                        nxt      = ST_TAIL;
                        tmr_load = 1'b1;
                        tmr_val  = TAIL_LOAD;
                    end else begin
                        nxt = ST_IDLE;
                    end
                end
            end
            ST_TAIL: begin
                if (tmr_zero) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ack_q   <= 1'b0;
            busy_q  <= 1'b0;
        end else if (soft_rst) begin
            state_q <= ST_IDLE;
            ack_q   <= 1'b0;
            busy_q  <= flow_busy;
        end else begin
            state_q <= nxt;
            ack_q   <= (nxt == ST_ACK);
            busy_q  <= flow_busy | (mode.busy_hs && (nxt != ST_IDLE));
        end
    end

    assign ack_out  = ack_q;
    assign busy_out = busy_q;
    assign idle     = (state_q == ST_IDLE);

    // R2: flow-control conditions force busy one cycle later
    p_flow_busy_r2: assert property (@(posedge clk) disable iff (rst)
        (!dma_en || fifo_full) |=> busy_out);

    // R8: no acknowledge starts from idle when the ack handshake is off
    p_ack_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (idle && !mode.ack_hs && !ack_out) |=> !ack_out);

    // R9: an acknowledge that ends on its own lasted at least three cycles
    p_ack_min_width_r9: assert property (@(posedge clk) disable iff (rst)
        ($fell(ack_out) && !$past(soft_rst)) |-> $past(ack_out, 3));

    // R7: busy outlives the acknowledge when both handshakes are on
    p_tail_busy_r7: assert property (@(posedge clk) disable iff (rst)
        ($fell(ack_out) && mode.busy_hs && !$past(soft_rst)) |-> busy_out);

    // R11: soft reset returns to idle with acknowledge low
    p_soft_idle_r11: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (idle && !ack_out));

    // R12: acknowledge never shows while idle
    p_idle_no_ack_r12: assert property (@(posedge clk) disable iff (rst)
        idle |-> !ack_out);

endmodule

// File: rtl/pp_rx_handshake.sv
module pp_rx_handshake
    import pp_rx_pkg::*;
#(
    parameter int DATA_W      = DEF_DATA_W,
    parameter int TIMER_W     = DEF_TIMER_W,
    parameter int SYNC_STAGES = DEF_SYNC_STAGES,
    parameter int MIN_WIDTH   = DEF_MIN_WIDTH,
    parameter int TAIL_CYCLES = DEF_TAIL_CYCLES
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               soft_rst,
    input  logic               cfg_busy_hs,
    input  logic               cfg_ack_hs,
    input  logic [TIMER_W-1:0] cfg_setup,
    input  logic [TIMER_W-1:0] cfg_width,
    input  logic               dma_en,
    input  logic               fifo_full,
    input  logic               strobe_in,
    input  logic [DATA_W-1:0]  data_in,
    output logic               wr_en,
    output logic [DATA_W-1:0]  wr_data,
    output logic               ack_out,
    output logic               busy_out,
    output logic               idle
);

    hs_mode_t           mode;
    strb_ev_t           ev;
    logic               tmr_load, tmr_zero, capture;
    logic [TIMER_W-1:0] tmr_val;
    logic               wr_en_q;
    logic [DATA_W-1:0]  wr_data_q;

    assign mode.busy_hs = cfg_busy_hs;
    assign mode.ack_hs  = cfg_ack_hs;

    pp_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (strobe_in),
        .ev  (ev)
    );

    pp_rx_timer #(.W(TIMER_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .clr      (soft_rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    pp_rx_ctrl #(
        .TIMER_W     (TIMER_W),
        .MIN_WIDTH   (MIN_WIDTH),
        .TAIL_CYCLES (TAIL_CYCLES)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .soft_rst  (soft_rst),
        .mode      (mode),
        .setup_cnt (cfg_setup),
        .width_cnt (cfg_width),
        .dma_en    (dma_en),
        .fifo_full (fifo_full),
        .ev        (ev),
        .tmr_zero  (tmr_zero),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .capture   (capture),
        .ack_out   (ack_out),
        .busy_out  (busy_out),
        .idle      (idle)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_en_q   <= 1'b0;
            wr_data_q <= '0;
        end else begin
            wr_en_q <= capture & ~soft_rst;
            if (capture) wr_data_q <= data_in;
        end
    end

    assign wr_en   = wr_en_q;
    assign wr_data = wr_data_q;

    // R3: a FIFO write lasts a single cycle
    p_single_write_r3: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);

    // R4: busy is already present in the capture cycle when busy handshake is on
    p_busy_on_capture_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && cfg_busy_hs) |-> busy_out);

endmodule

// File: tb/pp_rx_handshake_tb_top.sv
`timescale 1ns/1ps
module pp_rx_handshake_tb_top;

    logic       clk = 1'b0;
    logic       rst, soft_rst;
    logic       cfg_busy_hs, cfg_ack_hs;
    logic [6:0] cfg_setup, cfg_width;
    logic       dma_en, fifo_full, strobe_in;
    logic [7:0] data_in;
    logic       wr_en, ack_out, busy_out, idle;
    logic [7:0] wr_data;

    int n_run  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    pp_rx_handshake dut_i (
        .clk(clk), .rst(rst), .soft_rst(soft_rst),
        .cfg_busy_hs(cfg_busy_hs), .cfg_ack_hs(cfg_ack_hs),
        .cfg_setup(cfg_setup), .cfg_width(cfg_width),
        .dma_en(dma_en), .fifo_full(fifo_full),
        .strobe_in(strobe_in), .data_in(data_in),
        .wr_en(wr_en), .wr_data(wr_data),
        .ack_out(ack_out), .busy_out(busy_out), .idle(idle)
    );

    // {mode[1:0], setup[6:0], width[6:0], hold[3:0], data[7:0]}
    localparam logic [27:0] VEC [9] = '{
        {2'b00, 7'd5,   7'd5,   4'd2, 8'hA5},
        {2'b01, 7'd0,   7'd0,   4'd1, 8'h3C},
        {2'b01, 7'd6,   7'd9,   4'd4, 8'h81},
        {2'b10, 7'd0,   7'd4,   4'd2, 8'h00},
        {2'b10, 7'd11,  7'd4,   4'd3, 8'hFF},
        {2'b11, 7'd2,   7'd3,   4'd2, 8'h5A},
        {2'b11, 7'd0,   7'd2,   4'd5, 8'hC3},
        {2'b01, 7'd3,   7'd1,   4'd2, 8'h17},
        {2'b11, 7'd127, 7'd127, 4'd1, 8'h42}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t",
                     req, what, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    // One full transfer, checked on every cycle against the requirement timing
    task automatic run_xfer(input logic [1:0] m, input int dss, input int dsw,
                            input int h, input logic [7:0] d);
        int w      = (dsw < 3) ? 3 : dsw;
        int tend   = h + 10 + dss + w;
        int wr_cnt = 0;
        int last_busy_t;
        logic e_ack, e_busy, e_idle;
        string ack_tag, busy_tag;
        @(negedge clk);
        cfg_busy_hs = m[1]; cfg_ack_hs = m[0];
        cfg_setup = 7'(dss); cfg_width = 7'(dsw);
        @(negedge clk);
        @(negedge clk);
        ack_tag  = (m[0] == 1'b0) ? "R8" : ((dsw < 3) ? "R9" : "R5");
        busy_tag = (m == 2'b10) ? "R6" : ((m == 2'b11) ? "R7" : "R1");
        case (m)
            2'b00:   last_busy_t = h + 2;
            2'b01:   last_busy_t = h + 3 + dss + w;
            2'b10:   last_busy_t = h + 3 + dss;
            default: last_busy_t = h + 6 + dss + w;
        endcase
        strobe_in = 1'b1;
        data_in   = d;
        for (int t = 1; t <= tend; t++) begin
            @(negedge clk);
            e_ack  = m[0] && (t >= h + 4 + dss) && (t <= h + 3 + dss + w);
            e_busy = m[1] && (t >= 3) &&
                     (m[0] ? (t <= h + 6 + dss + w) : (t <= h + 3 + dss));
            e_idle = !((t >= 3) && (t <= last_busy_t));
            chk(ack_tag, "ack_out", 32'(ack_out), 32'(e_ack));
            chk((t == 3 && m[1]) ? "R4" : busy_tag, "busy_out",
                32'(busy_out), 32'(e_busy));
            chk("R12", "idle", 32'(idle), 32'(e_idle));
            if (wr_en) begin
                wr_cnt++;
                chk("R3", "wr_en cycle", 32'(t), 32'd3);
                chk("R3", "wr_data", 32'(wr_data), 32'(d));
            end
            if (t == h) strobe_in = 1'b0;
        end
        chk("R3", "writes per strobe", 32'(wr_cnt), 32'd1);
    endtask

    initial begin
        #500000;
        n_fail++;
        $display("FAIL watchdog: actual=expired expected=finished");
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1; soft_rst = 1'b0;
        cfg_busy_hs = 1'b0; cfg_ack_hs = 1'b0;
        cfg_setup = '0; cfg_width = '0;
        dma_en = 1'b1; fifo_full = 1'b0;
        strobe_in = 1'b0; data_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12: reset state
        chk("R12", "reset idle", 32'(idle), 32'd1);
        chk("R12", "reset ack", 32'(ack_out), 32'd0);
        chk("R12", "reset busy", 32'(busy_out), 32'd0);
        chk("R12", "reset wr_en", 32'(wr_en), 32'd0);

        // R1/R3-R9/R12: table of transfers across all four selects
        foreach (VEC[i]) begin
            run_xfer(VEC[i][27:26], int'(VEC[i][25:19]), int'(VEC[i][18:12]),
                     int'(VEC[i][11:8]), VEC[i][7:0]);
        end

        // R2: flow-control busy in select 00 and 01
        @(negedge clk);
        cfg_busy_hs = 1'b0; cfg_ack_hs = 1'b0;
        fifo_full = 1'b1;
        @(negedge clk);
        chk("R2", "busy on fifo_full", 32'(busy_out), 32'd1);
        fifo_full = 1'b0; dma_en = 1'b0; cfg_ack_hs = 1'b1;
        @(negedge clk);
        chk("R2", "busy on dma off", 32'(busy_out), 32'd1);
        dma_en = 1'b1;
        @(negedge clk);
        chk("R2", "busy released", 32'(busy_out), 32'd0);

        // R10: second strobe during the setup wait is ignored
        begin
            int wr_cnt = 0;
            logic e_ack;
            cfg_busy_hs = 1'b0; cfg_ack_hs = 1'b1;
            cfg_setup = 7'd20; cfg_width = 7'd4;
            @(negedge clk);
            strobe_in = 1'b1; data_in = 8'h66;
            for (int t = 1; t <= 36; t++) begin
                @(negedge clk);
                e_ack = (t >= 26) && (t <= 29);
                chk("R10", "ack with stray strobe", 32'(ack_out), 32'(e_ack));
                if (wr_en) wr_cnt++;
                if (t == 2)  strobe_in = 1'b0;
                if (t == 8)  begin strobe_in = 1'b1; data_in = 8'h99; end
                if (t == 11) strobe_in = 1'b0;
            end
            chk("R10", "writes with stray strobe", 32'(wr_cnt), 32'd1);
            chk("R10", "data kept", 32'(wr_data), 32'h66);
        end

        // R11: soft reset in the middle of the acknowledge
        cfg_busy_hs = 1'b1; cfg_ack_hs = 1'b1;
        cfg_setup = 7'd1; cfg_width = 7'd10;
        @(negedge clk);
        strobe_in = 1'b1; data_in = 8'h24;
        for (int t = 1; t <= 9; t++) begin
            @(negedge clk);
            if (t == 2) strobe_in = 1'b0;
        end
        chk("R11", "ack before soft reset", 32'(ack_out), 32'd1);
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
        chk("R11", "idle after soft reset", 32'(idle), 32'd1);
        chk("R11", "ack after soft reset", 32'(ack_out), 32'd0);
        chk("R11", "busy after soft reset", 32'(busy_out), 32'd0);
        @(negedge clk);
        chk("R11", "ack stays low", 32'(ack_out), 32'd0);
        run_xfer(2'b11, 1, 4, 2, 8'h7E);

        summary();
        $finish;
    end

endmodule